// File: doc/BRIEF.md
# Dual-Page Task Sequencer

This block keeps two complete parameter sets for a downstream video scaler, called page A and page B, and decides cycle by cycle which of them drives the scaler. Each page describes one scaling task: a source select, an input acquisition window, output dimensions, a prescale factor, a vertical scale value and a horizontal phase step. A horizontal timer and a vertical timer, both driven by the sync pulses, place the current pixel and line so that the block can flag the samples that lie inside the active window.

Two scheduling modes exist. In alternating mode, the field identity seen at each field start picks the page, so odd and even fields can be processed with different tasks. In region mode, one field is split: page A runs from the field start, and page B takes over at a programmed boundary line and keeps the rest of the field. Software writes through a simple register port into shadow copies. The copies that drive the outputs are refreshed only at task boundaries, so a running task never sees a half-written parameter set.

Top module: `task_page_sequencer`

## Requirements
- R1: During and right after reset the task ID is 0 (page A), task_active and in_window are 0, and every parameter output is 0.
- R2: A register write (wr_en with wr_page 0 for A or 1 for B, wr_addr, wr_data) changes only a shadow copy; parameter outputs do not move until the next task boundary. Address map per page: 0 control (bit0 region mode, bit1 run enable, bits3:2 source select), 1 x start, 2 x stop, 3 y start, 4 y stop, 5 output width, 6 output height, 7 prescale (low 4 bits used), 8 vertical scale, 9 horizontal phase, 10 region boundary line.
- R3: On a cycle with vsync high (field start), the live copies of both pages are loaded from their shadows, and the outputs show the new values from the next cycle.
- R4: When the shadow region-mode bit of page A is 0 at a field start, the task ID becomes field_id (0 selects A, 1 selects B) for the whole field.
- R5: When the shadow region-mode bit of page A is 1 at a field start, page A is selected regardless of field_id; on the hsync that makes the line number equal to page A's boundary value, page B is selected (and both live copies reload) until the next field start. A boundary of 0 never triggers.
- R6: The task ID changes only in the cycle after a vsync or hsync pulse; field_id moving mid-line has no effect.
- R7: vsync clears the pixel and line counters; hsync (without vsync) clears the pixel counter and advances the line counter; on other cycles the pixel counter advances by one.
- R8: in_window is 1 exactly when the active page is running and x start <= pixel < x stop and y start <= line < y stop.
- R9: task_active equals the run-enable bit of the active page; with it clear, in_window stays 0.
- R10: The parameter outputs show the fields of the page selected by the task ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_page | input | 1 | Page addressed by the write (0 = A, 1 = B) |
| wr_addr | input | 4 | Register address within the page |
| wr_data | input | REG_W | Write data |
| hsync | input | 1 | One-cycle line start pulse |
| vsync | input | 1 | One-cycle field start pulse |
| field_id | input | 1 | Field identity, sampled at vsync |
| task_id | output | 1 | Active page (0 = A, 1 = B) |
| task_active | output | 1 | Run-enable bit of the active page |
| in_window | output | 1 | Current pixel and line lie in the input window |
| src_sel | output | 2 | Source select of the active page |
| win_x_start | output | REG_W | Window first pixel |
| win_x_stop | output | REG_W | Window pixel limit (exclusive) |
| win_y_start | output | REG_W | Window first line |
| win_y_stop | output | REG_W | Window line limit (exclusive) |
| out_width | output | REG_W | Output width |
| out_height | output | REG_W | Output height |
| prescale | output | 4 | Horizontal prescale factor |
| vscale | output | REG_W | Vertical scale value |
| hphase | output | REG_W | Horizontal phase step |

## Verification
The assertions take the sync inputs as single-cycle pulses and expect register writes never to land on a boundary cycle, since a write there reaches the live copy only at the following boundary. The checks on page selection compare the task ID with field_id and the shadow mode bit sampled on the vsync cycle. They rely on field_id being steady on that cycle. The stimulus drives every input on the falling edge, keeps hsync and vsync apart with idle cycles in between, and issues all writes while no sync pulse is present.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int NPAGE = 2;
  localparam int NREG  = 11;
  localparam int AW    = 4;

  localparam int R_CTRL   = 0;
  localparam int R_XSTART = 1;
  localparam int R_XSTOP  = 2;
  localparam int R_YSTART = 3;
  localparam int R_YSTOP  = 4;
  localparam int R_OUTW   = 5;
  localparam int R_OUTH   = 6;
  localparam int R_PRESC  = 7;
  localparam int R_VSCALE = 8;
  localparam int R_HPHASE = 9;
  localparam int R_BOUND  = 10;

  localparam int C_MODE = 0;
  localparam int C_RUN  = 1;

  typedef enum logic {TASK_A = 1'b0, TASK_B = 1'b1} task_e;
endpackage

// File: rtl/tps_page_bank.sv
module tps_page_bank
  import tps_pkg::*;
#(
  parameter int REG_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_page,
  input  logic [AW-1:0] wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic load,
  output logic shadow_mode_a,
  output logic [NPAGE-1:0][NREG-1:0][REG_W-1:0] live_o
);
  logic [NPAGE-1:0][NREG-1:0][REG_W-1:0] shadow_q;
  logic [NPAGE-1:0][NREG-1:0][REG_W-1:0] live_q;

  for (genvar p = 0; p < NPAGE; p++) begin : g_page
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          shadow_q[p][r] <= '0;
          live_q[p][r]   <= '0;
        end else begin
          if (wr_en && wr_page == 1'(p) && wr_addr == AW'(r))
            shadow_q[p][r] <= wr_data;
          if (load)
            live_q[p][r] <= shadow_q[p][r];
        end
      end
    end
  end

  assign shadow_mode_a = shadow_q[0][R_CTRL][C_MODE];
  assign live_o = live_q;

  assert_live_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> $stable(live_q));
  assert_live_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) |-> live_q == $past(shadow_q));
endmodule

// File: rtl/tps_timing.sv
module tps_timing #(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync,
  input  logic vsync,
  output logic [CNT_W-1:0] pix_o,
  output logic [CNT_W-1:0] line_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] pix_q, line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_q  <= '0;
      line_q <= '0;
    end else if (vsync) begin
      pix_q  <= '0;
      line_q <= '0;
    end else if (hsync) begin
      pix_q  <= '0;
      if (line_q != CNT_MAX) line_q <= line_q + 1'b1;
    end else if (pix_q != CNT_MAX) begin
      pix_q <= pix_q + 1'b1;
    end
  end

  assign pix_o  = pix_q;
  assign line_o = line_q;

  assert_pix_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hsync || vsync) |-> pix_q == '0);
  assert_line_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hsync && !vsync) && $past(line_q) != CNT_MAX) |-> line_q == $past(line_q) + 1'b1);
endmodule

// File: rtl/tps_task_select.sv
module tps_task_select
  import tps_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync,
  input  logic vsync,
  input  logic field_id,
  input  logic shadow_mode_a,
  input  logic live_mode_a,
  input  logic [CNT_W-1:0] boundary,
  input  logic [CNT_W-1:0] line_cnt,
  output task_e sel_o,
  output logic load_o
);
  task_e sel_q;
  logic  bnd_hit;
  logic [CNT_W-1:0] next_line;

  assign next_line = line_cnt + 1'b1;
  assign bnd_hit   = hsync && !vsync && live_mode_a && (next_line == boundary);
  assign load_o    = vsync || bnd_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)
      sel_q <= TASK_A;
    else if (vsync)
      sel_q <= shadow_mode_a ? TASK_A : task_e'(field_id);
    else if (bnd_hit)
      sel_q <= TASK_B;
  end

  assign sel_o = sel_q;

  assert_switch_on_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(hsync || vsync));
  assert_alt_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vsync) && !$past(shadow_mode_a)) |-> (sel_q == task_e'($past(field_id))));
  assert_region_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vsync) && $past(shadow_mode_a)) |-> (sel_q == TASK_A));
endmodule

// File: rtl/task_page_sequencer.sv
module task_page_sequencer
  import tps_pkg::*;
#(
  parameter int REG_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_page,
  input  logic [3:0] wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic hsync,
  input  logic vsync,
  input  logic field_id,
  output logic task_id,
  output logic task_active,
  output logic in_window,
  output logic [1:0] src_sel,
  output logic [REG_W-1:0] win_x_start,
  output logic [REG_W-1:0] win_x_stop,
  output logic [REG_W-1:0] win_y_start,
  output logic [REG_W-1:0] win_y_stop,
  output logic [REG_W-1:0] out_width,
  output logic [REG_W-1:0] out_height,
  output logic [3:0] prescale,
  output logic [REG_W-1:0] vscale,
  output logic [REG_W-1:0] hphase
);
  logic [NPAGE-1:0][NREG-1:0][REG_W-1:0] live;
  logic [NREG-1:0][REG_W-1:0] act;
  logic [REG_W-1:0] pix, line;
  logic load, shadow_mode_a;
  task_e sel;

  tps_page_bank #(.REG_W(REG_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_page(wr_page),
    .wr_addr(wr_addr), .wr_data(wr_data), .load(load),
    .shadow_mode_a(shadow_mode_a), .live_o(live)
  );

  tps_timing #(.CNT_W(REG_W)) u_timing (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .pix_o(pix), .line_o(line)
  );

  tps_task_select #(.CNT_W(REG_W)) u_select (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .field_id(field_id), .shadow_mode_a(shadow_mode_a),
    .live_mode_a(live[0][R_CTRL][C_MODE]), .boundary(live[0][R_BOUND]),
    .line_cnt(line), .sel_o(sel), .load_o(load)
  );

  assign act         = (sel == TASK_B) ? live[1] : live[0];
  assign task_id     = sel;
  assign task_active = act[R_CTRL][C_RUN];
  assign src_sel     = act[R_CTRL][3:2];
  assign win_x_start = act[R_XSTART];
  assign win_x_stop  = act[R_XSTOP];
  assign win_y_start = act[R_YSTART];
  assign win_y_stop  = act[R_YSTOP];
  assign out_width   = act[R_OUTW];
  assign out_height  = act[R_OUTH];
  assign prescale    = act[R_PRESC][3:0];
  assign vscale      = act[R_VSCALE];
  assign hphase      = act[R_HPHASE];

  assign in_window = task_active
                  && (pix >= act[R_XSTART]) && (pix < act[R_XSTOP])
                  && (line >= act[R_YSTART]) && (line < act[R_YSTOP]);

  assert_outputs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && $stable(sel)) |-> ($stable(win_x_start) && $stable(vscale) && $stable(src_sel)));
endmodule

// File: tb/test_task_page_sequencer.sv
module test_task_page_sequencer;
  localparam int REG_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_page = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [REG_W-1:0] wr_data = '0;
  logic hsync = 1'b0, vsync = 1'b0, field_id = 1'b0;
  logic task_id, task_active, in_window;
  logic [1:0] src_sel;
  logic [REG_W-1:0] win_x_start, win_x_stop, win_y_start, win_y_stop;
  logic [REG_W-1:0] out_width, out_height, vscale, hphase;
  logic [3:0] prescale;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  task_page_sequencer #(.REG_W(REG_W)) i_task_page_sequencer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_page(wr_page), .wr_addr(wr_addr),
    .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .field_id(field_id),
    .task_id(task_id), .task_active(task_active), .in_window(in_window),
    .src_sel(src_sel), .win_x_start(win_x_start), .win_x_stop(win_x_stop),
    .win_y_start(win_y_start), .win_y_stop(win_y_stop), .out_width(out_width),
    .out_height(out_height), .prescale(prescale), .vscale(vscale), .hphase(hphase)
  );

  typedef struct packed {
    logic mode; logic fid; logic [3:0] bnd; logic [3:0] nh; logic exp_id;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b0, 4'd0, 4'd0, 1'b0},
    '{1'b0, 1'b1, 4'd0, 4'd0, 1'b1},
    '{1'b0, 1'b1, 4'd0, 4'd5, 1'b1},
    '{1'b0, 1'b0, 4'd0, 4'd3, 1'b0},
    '{1'b1, 1'b1, 4'd3, 4'd2, 1'b0},
    '{1'b1, 1'b1, 4'd3, 4'd3, 1'b1},
    '{1'b1, 1'b0, 4'd3, 4'd5, 1'b1},
    '{1'b1, 1'b0, 4'd0, 4'd6, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic pg, input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_page = pg; wr_addr = 4'(addr); wr_data = REG_W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_v(input logic fid);
    @(negedge clk);
    vsync = 1'b1; field_id = fid;
    @(negedge clk);
    vsync = 1'b0;
  endtask

  task automatic pulse_h();
    @(negedge clk);
    hsync = 1'b1;
    @(negedge clk);
    hsync = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 task_id", task_id, 0);
    check("R1 task_active", task_active, 0);
    check("R1 in_window", in_window, 0);
    check("R1 vscale", vscale, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 win_x_start after reset", win_x_start, 0);

    // R2/R3: shadow isolation and reload at field start
    wr(1'b0, 1, 5);
    repeat (3) @(negedge clk);
    check("R2 shadow write hidden", win_x_start, 0);
    pulse_v(1'b0);
    check("R3 reload at field start", win_x_start, 5);
    wr(1'b0, 1, 9);
    pulse_h();
    check("R2 hsync in alternate mode keeps live", win_x_start, 5);
    pulse_v(1'b0);
    check("R3 second reload", win_x_start, 9);

    // Table: page selection in both modes (R4, R5)
    wr(1'b1, 0, 12'h002);
    for (int i = 0; i < 8; i++) begin
      wr(1'b0, 0, {10'd0, 1'b1, VEC[i].mode});
      wr(1'b0, 10, int'(VEC[i].bnd));
      pulse_v(VEC[i].fid);
      for (int h = 0; h < int'(VEC[i].nh); h++) pulse_h();
      if (VEC[i].mode) check($sformatf("R5 vector %0d", i), task_id, VEC[i].exp_id);
      else             check($sformatf("R4 vector %0d", i), task_id, VEC[i].exp_id);
    end

    // R10: page B fields on the output bus
    wr(1'b0, 0, 12'h002);
    wr(1'b1, 0, 12'h00A);
    wr(1'b1, 1, 11); wr(1'b1, 2, 200); wr(1'b1, 3, 7); wr(1'b1, 4, 100);
    wr(1'b1, 5, 320); wr(1'b1, 6, 240); wr(1'b1, 7, 12'h0F7);
    wr(1'b1, 8, 12'h123); wr(1'b1, 9, 12'h456);
    pulse_v(1'b1);
    check("R10 task_id B", task_id, 1);
    check("R10 src_sel", src_sel, 2);
    check("R10 win_x_stop", win_x_stop, 200);
    check("R10 win_y_start", win_y_start, 7);
    check("R10 out_width", out_width, 320);
    check("R10 out_height", out_height, 240);
    check("R10 prescale", prescale, 7);
    check("R10 vscale", vscale, 12'h123);
    check("R10 hphase", hphase, 12'h456);

    // R6: field_id changing mid-line has no effect
    @(negedge clk); field_id = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 mid-line field change ignored", task_id, 1);

    // R7/R8: window on page A, x 4..8, y 1..3
    wr(1'b0, 1, 4); wr(1'b0, 2, 8); wr(1'b0, 3, 1); wr(1'b0, 4, 3);
    pulse_v(1'b0);
    repeat (5) @(negedge clk);
    check("R8 line 0 outside window", in_window, 0);
    pulse_h();
    // one negedge already passed inside pulse_h after the clearing edge: pix = 1
    for (int k = 1; k < 10; k++) begin
      check($sformatf("R7 R8 pixel %0d line 1", k), in_window, (k >= 4 && k < 8) ? 1 : 0);
      @(negedge clk);
    end
    pulse_h(); pulse_h();
    repeat (4) @(negedge clk);
    check("R8 line 3 outside window", in_window, 0);

    // R9: run enable cleared
    wr(1'b0, 0, 12'h000);
    pulse_v(1'b0);
    pulse_h();
    repeat (4) @(negedge clk);
    check("R9 task_active off", task_active, 0);
    check("R9 in_window off", in_window, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule